// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block receives the three-wire programming stream of a frequency synthesizer and holds the programmed values. A host clocks one bit per rising edge of the serial clock, most significant bit first. A rising edge on the load strobe then copies the word into one of three registers. The last two bits of the word choose the register: the reference divider, the feedback divider or the function register.

The three serial lines run asynchronously to the system clock. Each one passes through a synchronizer, and its edges are detected in the system clock domain. Every output is a register, and each output changes only when a valid word is loaded or on reset.

A reference word whose test field is not zero is refused. The held values do not change, and an error flag is raised. Analog functions that these fields control are outside this block.

Top module: `synth_prog_if`

## Requirements
- R1: On each rising edge of `ser_clk` the value on `ser_data` enters the shift register, most significant bit first. Only the last 21 bits shifted in before a load count, so a longer stream keeps its final 21 bits.
- R2: Shifting alone never changes an output. Register contents move to a latch only on a rising edge of `ser_le`.
- R3: The two bits shifted in last are the control pair. The first of the pair is C1 and the final bit is C2. {C1,C2}=00 selects the reference register, 10 the feedback register and 01 the function register. For 11 the load is ignored and every output keeps its value.
- R4: Data bits are numbered 19 (shifted in first) down to 1. A reference word carries the lock-detect precision bit in bit 19, test bits in 18..15 and the reference ratio in 14..1, with bit 1 as the ratio LSB. For example, ratio 50 is 00000000110010.
- R5: A reference word whose test bits are not all zero leaves the reference outputs unchanged and sets `ref_test_err`. A valid reference word clears `ref_test_err`.
- R6: A feedback word carries the GO bit in bit 19, B in bits 18..6 and A in bits 5..1. The LSB of each field is the lower bit number.
- R7: A function word loads data bits 19..1 into `func_bits[18:0]`, so bit 1 lands in `func_bits[0]`. `cnt_reset` follows function bit 1 (F1), the counter-reset control for both dividers.
- R8: Synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge transfers the word |
| ref_ld_prec | output | 1 | Lock-detect precision bit |
| ref_ratio | output | 14 | Reference divide ratio |
| ref_test_err | output | 1 | Last reference word had nonzero test bits |
| fb_go | output | 1 | GO bit of the feedback word |
| fb_b | output | 13 | Feedback B value |
| fb_a | output | 5 | Feedback A value |
| func_bits | output | 19 | Function register bits 19..1 |
| cnt_reset | output | 1 | Counter-reset control (function bit 1) |

## Verification
Several properties are checked on every cycle:
- the shift register holds when no serial clock edge arrives;
- the latches hold without a load pulse;
- a control pair of 11 leaves every output stable;
- a refused reference word keeps the ratio and raises the flag;
- `cnt_reset` tracks bit 1 of each function word;
- reset clears everything.

Only the bench scenarios can show the things that need whole streams. These are the exact field placement of B, A, the ratio and GO against known words, MSB-first ordering, the keeping of the last 21 bits from an overlong stream, and the error flag clearing after a later valid word.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  // {C1,C2}: C1 is the second-last bit shifted in, C2 the last
  typedef enum logic [1:0] {
    SEL_REF = 2'b00,
    SEL_FUN = 2'b01,
    SEL_FB  = 2'b10,
    SEL_RSV = 2'b11
  } latch_sel_e;

  localparam int CTRL_W = 2;

  function automatic latch_sel_e decode_sel(input logic [CTRL_W-1:0] ctrl);
    return latch_sel_e'(ctrl);
  endfunction
endpackage

// File: rtl/serial_edge_sync.sv
module serial_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic data_in,
  input  logic le_in,
  output logic shift_pulse,
  output logic shift_bit,
  output logic load_pulse
);
  // lane order: [2]=le, [1]=sclk, [0]=data
  logic [STAGES-1:0][2:0] q;
  logic prev_sclk, prev_le;

  always_ff @(posedge clk) begin
    if (rst) q[0] <= '0;
    else     q[0] <= {le_in, sclk_in, data_in};
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) q[g] <= '0;
        else     q[g] <= q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b0;
      prev_le   <= 1'b0;
    end else begin
      prev_sclk <= q[STAGES-1][1];
      prev_le   <= q[STAGES-1][2];
    end
  end

  assign shift_pulse = q[STAGES-1][1] & ~prev_sclk;
  assign load_pulse  = q[STAGES-1][2] & ~prev_le;
  assign shift_bit   = q[STAGES-1][0];

  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> !shift_pulse); // R1
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse); // R2
endmodule

// File: rtl/prog_shift_reg.sv
module prog_shift_reg #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end

  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word)); // R1
  AST_SR_ORDER: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0])); // R1
endmodule

// File: rtl/prog_latch_bank.sv
module prog_latch_bank
  import synth_prog_pkg::*;
#(
  parameter int RATIO_W = 14,
  parameter int TEST_W  = 4,
  parameter int B_W     = 13,
  parameter int A_W     = 5,
  localparam int DATA_W = 1 + TEST_W + RATIO_W,
  localparam int WORD_W = DATA_W + CTRL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WORD_W-1:0]  word,
  output logic               ref_ld_prec,
  output logic [RATIO_W-1:0] ref_ratio,
  output logic               ref_test_err,
  output logic               fb_go,
  output logic [B_W-1:0]     fb_b,
  output logic [A_W-1:0]     fb_a,
  output logic [DATA_W-1:0]  func_bits,
  output logic               cnt_reset
);
  localparam int RATIO_LO = CTRL_W;
  localparam int TEST_LO  = CTRL_W + RATIO_W;
  localparam int A_LO     = CTRL_W;
  localparam int B_LO     = CTRL_W + A_W;
  localparam int TOP_BIT  = WORD_W - 1;

  latch_sel_e          sel;
  logic [TEST_W-1:0]   test_f;
  logic                test_bad;

  assign sel      = decode_sel(word[CTRL_W-1:0]);
  assign test_f   = word[TEST_LO +: TEST_W];
  assign test_bad = |test_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_ld_prec  <= 1'b0;
      ref_ratio    <= '0;
      ref_test_err <= 1'b0;
      fb_go        <= 1'b0;
      fb_b         <= '0;
      fb_a         <= '0;
      func_bits    <= '0;
      cnt_reset    <= 1'b0;
    end else if (load) begin
      unique case (sel)
        SEL_REF: begin
          if (test_bad) begin
            ref_test_err <= 1'b1;
          end else begin
            ref_test_err <= 1'b0;
            ref_ld_prec  <= word[TOP_BIT];
            ref_ratio    <= word[RATIO_LO +: RATIO_W];
          end
        end
        SEL_FB: begin
          fb_go <= word[TOP_BIT];
          fb_b  <= word[B_LO +: B_W];
          fb_a  <= word[A_LO +: A_W];
        end
        SEL_FUN: begin
          func_bits <= word[TOP_BIT:CTRL_W];
          cnt_reset <= word[CTRL_W];
        end
        SEL_RSV: ;
      endcase
    end
  end

  logic [DATA_W+RATIO_W+B_W+A_W+4:0] all_out;
  assign all_out = {ref_ld_prec, ref_ratio, ref_test_err, fb_go, fb_b, fb_a,
                    func_bits, cnt_reset};

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(all_out)); // R2
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (load && word[CTRL_W-1:0] == 2'b11) |=> $stable(all_out)); // R3
  AST_TEST_REJECT: assert property (@(posedge clk) disable iff (rst)
    (load && word[CTRL_W-1:0] == 2'b00 && word[TEST_LO +: TEST_W] != '0)
      |=> (ref_test_err && $stable(ref_ratio) && $stable(ref_ld_prec))); // R5
  AST_CNT_RESET_F1: assert property (@(posedge clk) disable iff (rst)
    (load && word[CTRL_W-1:0] == 2'b01) |=> cnt_reset == $past(word[CTRL_W])); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> all_out == '0); // R8
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if #(
  parameter int RATIO_W     = 14,
  parameter int TEST_W      = 4,
  parameter int B_W         = 13,
  parameter int A_W         = 5,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = 1 + TEST_W + RATIO_W,
  localparam int WORD_W     = DATA_W + synth_prog_pkg::CTRL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  output logic               ref_ld_prec,
  output logic [RATIO_W-1:0] ref_ratio,
  output logic               ref_test_err,
  output logic               fb_go,
  output logic [B_W-1:0]     fb_b,
  output logic [A_W-1:0]     fb_a,
  output logic [DATA_W-1:0]  func_bits,
  output logic               cnt_reset
);
  logic              shift_pulse, shift_bit, load_pulse;
  logic [WORD_W-1:0] word;

  serial_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sclk_in(ser_clk), .data_in(ser_data), .le_in(ser_le),
    .shift_pulse(shift_pulse), .shift_bit(shift_bit), .load_pulse(load_pulse)
  );

  prog_shift_reg #(.WORD_W(WORD_W)) u_sr (
    .clk(clk), .rst(rst),
    .shift_en(shift_pulse), .bit_in(shift_bit), .word(word)
  );

  prog_latch_bank #(
    .RATIO_W(RATIO_W), .TEST_W(TEST_W), .B_W(B_W), .A_W(A_W)
  ) u_bank (
    .clk(clk), .rst(rst), .load(load_pulse), .word(word),
    .ref_ld_prec(ref_ld_prec), .ref_ratio(ref_ratio), .ref_test_err(ref_test_err),
    .fb_go(fb_go), .fb_b(fb_b), .fb_a(fb_a),
    .func_bits(func_bits), .cnt_reset(cnt_reset)
  );
endmodule

// File: tb/synth_prog_if_tb.sv
module synth_prog_if_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic        ref_ld_prec, ref_test_err, fb_go, cnt_reset;
  logic [13:0] ref_ratio;
  logic [12:0] fb_b;
  logic [4:0]  fb_a;
  logic [18:0] func_bits;

  always #5 clk = ~clk;

  synth_prog_if dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_ld_prec(ref_ld_prec), .ref_ratio(ref_ratio), .ref_test_err(ref_test_err),
    .fb_go(fb_go), .fb_b(fb_b), .fb_a(fb_a), .func_bits(func_bits),
    .cnt_reset(cnt_reset)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [20:0] word;
    logic        ldp;
    logic [13:0] ratio;
    logic        err;
    logic        go;
    logic [12:0] b;
    logic [4:0]  a;
    logic [18:0] f;
  } vec_t;

  // cumulative expectations, starting from the reset state
  localparam vec_t VECS [8] = '{
    // R4: ratio 50, precision bit set
    '{4'd4, {1'b1, 4'b0, 14'd50, 2'b00}, 1'b1, 14'd50, 1'b0, 1'b0, 13'd0, 5'd0, 19'h0},
    // R6: B=148 A=14
    '{4'd6, {1'b0, 13'd148, 5'd14, 2'b10}, 1'b1, 14'd50, 1'b0, 1'b0, 13'd148, 5'd14, 19'h0},
    // R7: function word with F1 set
    '{4'd7, {19'h20003, 2'b01}, 1'b1, 14'd50, 1'b0, 1'b0, 13'd148, 5'd14, 19'h20003},
    // R5: test bits nonzero, refused
    '{4'd5, {1'b0, 4'b0100, 14'd99, 2'b00}, 1'b1, 14'd50, 1'b1, 1'b0, 13'd148, 5'd14, 19'h20003},
    // R3: reserved control pair ignored
    '{4'd3, {19'h7FFFF, 2'b11}, 1'b1, 14'd50, 1'b1, 1'b0, 13'd148, 5'd14, 19'h20003},
    // R5: valid reference word clears flag, max ratio
    '{4'd5, {1'b0, 4'b0, 14'h3FFF, 2'b00}, 1'b0, 14'h3FFF, 1'b0, 1'b0, 13'd148, 5'd14, 19'h20003},
    // R6: all-ones feedback fields with GO
    '{4'd6, {1'b1, 13'h1FFF, 5'h1F, 2'b10}, 1'b0, 14'h3FFF, 1'b0, 1'b1, 13'h1FFF, 5'h1F, 19'h20003},
    // R7: function word clearing counter reset
    '{4'd7, {19'h40000, 2'b01}, 1'b0, 14'h3FFF, 1'b0, 1'b1, 13'h1FFF, 5'h1F, 19'h40000}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [20:0] w);
    for (int i = 20; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le();
    wait_clk(4);
    ser_le = 1'b1;
    wait_clk(4);
    ser_le = 1'b0;
    wait_clk(8);
  endtask

  task automatic check(input vec_t e, input string tag);
    logic [54:0] got, exp;
    got = {ref_ld_prec, ref_ratio, ref_test_err, fb_go, fb_b, fb_a, func_bits, cnt_reset};
    exp = {e.ldp, e.ratio, e.err, e.go, e.b, e.a, e.f, e.f[0]};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  vec_t zero_v;
  vec_t tmp;

  initial begin
    zero_v = '0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    check(zero_v, "R8 reset state");

    for (int i = 0; i < 8; i++) begin
      send_word(VECS[i].word);
      pulse_le();
      check(VECS[i], $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R2: shifting a new word without a load changes nothing
    send_word({1'b0, 13'd5, 5'd3, 2'b10});
    wait_clk(8);
    check(VECS[7], "R2 shift without load");

    // R1: overlong stream, last 21 bits count
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    send_word({1'b0, 4'b0, 14'd77, 2'b00});
    pulse_le();
    tmp = VECS[7];
    tmp.ldp = 1'b0;
    tmp.ratio = 14'd77;
    check(tmp, "R1 overlong stream");

    // R8: reset mid-run clears everything
    @(negedge clk) rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(2);
    check(zero_v, "R8 reset after programming");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule